// File: doc/BRIEF.md
# Bus Ownership Handover Controller

This block decides when a bus master gives its bus to an external master and when it takes the bus back. The external master raises a request. The controller answers with a grant, but only at a bus-cycle boundary and only when no locked read-modify-write sequence is running. In the same cycle that the grant rises, the controller drops its own drive enable, so that its address, data and strobe drivers float. The external master confirms ownership with an acknowledge. The grant then falls. The controller stays off the bus until the acknowledge is withdrawn. After that it waits a fixed turnaround and drives again.

The request and acknowledge arrive from another clock domain. Each passes through a synchronizer chain of `SYNC_STAGES` flops before the state machine uses it. The turnaround between release and re-drive lasts `TURN_CYC` cycles. A request that is still held when the acknowledge drops is treated as a new request, so the grant is issued again. If the request goes away before any acknowledge, the offer is withdrawn and the bus is reclaimed through the same turnaround.

Top module: `busown_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `drive_en_o` is 1 and `bus_grant_o` is 0.
- R2: With `seq_locked_i`=0 and `cyc_idle_i`=1, a request applied before rising edge k raises `bus_grant_o` after edge k+SYNC_STAGES, and not earlier. With the default parameters this is the third edge.
- R3: `bus_grant_o` and `drive_en_o` are never 1 in the same cycle. `drive_en_o` falls in the cycle in which `bus_grant_o` rises.
- R4: While `seq_locked_i` is 1, the grant is not raised, even when a request is pending. Once the lock clears with the synchronized request high, the grant rises on the next edge.
- R5: While `cyc_idle_i` is 0, the grant is not raised. Once it returns to 1 with the synchronized request high, the grant rises on the next edge.
- R6: An acknowledge applied before edge k drops `bus_grant_o` after edge k+SYNC_STAGES. `drive_en_o` stays 0 for as long as the acknowledge is held.
- R7: An acknowledge removed before edge k leaves both outputs at 0 for `TURN_CYC` cycles, and `drive_en_o` rises after edge k+SYNC_STAGES+TURN_CYC.
- R8: A request removed before edge k while the grant is high and no acknowledge has come drops the grant after edge k+SYNC_STAGES, and `drive_en_o` rises `TURN_CYC` cycles later.
- R9: If the request is still held when the acknowledge is removed, the controller drives for one cycle after the turnaround and then raises the grant again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Request from the external master (asynchronous) |
| bus_ack_i | input | 1 | External master confirms it owns the bus (asynchronous) |
| seq_locked_i | input | 1 | A locked read-modify-write sequence is in progress (synchronous) |
| cyc_idle_i | input | 1 | The local bus sequencer is at a cycle boundary (synchronous) |
| bus_grant_o | output | 1 | Bus offered to the external master |
| drive_en_o | output | 1 | Local address, data and strobe drivers enabled |

## Verification
The properties assume three things about the inputs:
- The lock and cycle-boundary inputs are synchronous to `clk`.
- The external master raises the acknowledge only while it sees the grant high.
- The external master does not raise the acknowledge again during the reclaim turnaround.

Under these assumptions, a rising drive enable is always preceded by a synchronized acknowledge that is low. The stimulus stays within these limits. Inputs change only on falling clock edges. The emulated external master raises the acknowledge only after it has observed the grant, and it raises it only from a released state. The lock and boundary inputs are randomized freely, because the controller must tolerate any pattern of them.

// File: rtl/bac_pkg.sv
package bac_pkg;
   typedef enum logic [1:0] {
      ST_HOLD    = 2'd0,   // local master drives the bus
      ST_OFFER   = 2'd1,   // grant out, waiting for acknowledge
      ST_LENT    = 2'd2,   // external master owns the bus
      ST_RECLAIM = 2'd3    // turnaround before driving again
   } own_state_e;
endpackage

// File: rtl/bac_sync.sv
module bac_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("bac_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("bac_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/bac_reclaim_timer.sv
module bac_reclaim_timer #(
   parameter int TURN_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);
   localparam int CW = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;
   localparam logic [CW-1:0] START = CW'(TURN_CYC - 1);

   generate
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("bac_reclaim_timer: TURN_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= START;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/bac_fsm.sv
module bac_fsm
   import bac_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s_i,
   input  logic       ack_s_i,
   input  logic       locked_i,
   input  logic       idle_i,
   input  logic       turn_done_i,
   output logic       turn_load_o,
   output own_state_e state_o
);
   own_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_HOLD:    if (req_s_i && !locked_i && idle_i) st_d = ST_OFFER;
         ST_OFFER:   if (ack_s_i)                        st_d = ST_LENT;
                     else if (!req_s_i)                  st_d = ST_RECLAIM;
         ST_LENT:    if (!ack_s_i)                       st_d = ST_RECLAIM;
         ST_RECLAIM: if (turn_done_i)                    st_d = ST_HOLD;
         default:                                        st_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_HOLD;
      else        st_q <= st_d;
   end

   assign turn_load_o = (st_d == ST_RECLAIM) && (st_q != ST_RECLAIM);
   assign state_o     = st_q;
endmodule

// File: rtl/busown_arbiter.sv
module busown_arbiter
   import bac_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TURN_CYC    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req_i,
   input  logic bus_ack_i,
   input  logic seq_locked_i,
   input  logic cyc_idle_i,
   output logic bus_grant_o,
   output logic drive_en_o
);
   localparam int NUM_ASYNC = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("busown_arbiter: SYNC_STAGES must be at least 2");
      end
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("busown_arbiter: TURN_CYC must be at least 1");
      end
   endgenerate

   logic [NUM_ASYNC-1:0] raw_in, sync_out;
   logic req_s, ack_s;
   logic turn_load, turn_done;
   own_state_e own_st;

   assign raw_in = {bus_ack_i, bus_req_i};

   bac_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_out)
   );

   assign req_s = sync_out[0];
   assign ack_s = sync_out[1];

   bac_reclaim_timer #(.TURN_CYC(TURN_CYC)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (turn_load),
      .done_o (turn_done)
   );

   bac_fsm i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_s_i     (req_s),
      .ack_s_i     (ack_s),
      .locked_i    (seq_locked_i),
      .idle_i      (cyc_idle_i),
      .turn_done_i (turn_done),
      .turn_load_o (turn_load),
      .state_o     (own_st)
   );

   assign bus_grant_o = (own_st == ST_OFFER);
   assign drive_en_o  = (own_st == ST_HOLD);
endmodule

// File: rtl/bac_chk.sv
module bac_chk (
   input logic clk,
   input logic rst_n,
   input logic req_s,
   input logic ack_s,
   input logic locked,
   input logic idle,
   input logic grant,
   input logic drive
);
   // R3: never granted while driving
   p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && drive));

   // R2: a new grant follows a synchronized request at an unlocked boundary
   p_grant_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant) |-> ($past(req_s) && !$past(locked) && $past(idle)));

   // R4: lock seen at an edge keeps the grant low
   p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !grant) |=> !grant);

   // R5: no grant away from a cycle boundary
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !grant) |=> !grant);

   // R6: a synchronized acknowledge withdraws the grant
   p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && ack_s) |=> !grant);

   // R7: the grant never falls straight into local drive
   p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(grant) |-> !drive);

   // R7: drive only resumes after the acknowledge is gone
   p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive) |-> !$past(ack_s));
endmodule

bind busown_arbiter bac_chk i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req_s  (req_s),
   .ack_s  (ack_s),
   .locked (seq_locked_i),
   .idle   (cyc_idle_i),
   .grant  (bus_grant_o),
   .drive  (drive_en_o)
);

// File: tb/test_busown_arbiter.sv
module test_busown_arbiter;
   localparam int SYNC = 2;
   localparam int TURN = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_req_i = 1'b0, bus_ack_i = 1'b0;
   logic seq_locked_i = 1'b0, cyc_idle_i = 1'b1;
   logic bus_grant_o, drive_en_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   busown_arbiter #(.SYNC_STAGES(SYNC), .TURN_CYC(TURN)) i_busown_arbiter (
      .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .bus_ack_i(bus_ack_i),
      .seq_locked_i(seq_locked_i), .cyc_idle_i(cyc_idle_i),
      .bus_grant_o(bus_grant_o), .drive_en_o(drive_en_o));

   // Behavioural reference: 0 own, 1 offered, 2 lent, 3 turnaround
   int  mode;
   int  cnt;
   bit  m_r, m_a;
   bit  model_ok = 0;
   bit  rq_h[$];
   bit  ak_h[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         mode = 0; cnt = 0;
         rq_h = {}; ak_h = {};
         for (int i = 0; i < SYNC; i++) begin
            rq_h.push_back(1'b0);
            ak_h.push_back(1'b0);
         end
         model_ok = 1;
      end else if (model_ok) begin
         m_r = rq_h[$];
         m_a = ak_h[$];
         rq_h.push_front(bus_req_i); void'(rq_h.pop_back());
         ak_h.push_front(bus_ack_i); void'(ak_h.pop_back());
         case (mode)
            0: if (m_r && !seq_locked_i && cyc_idle_i) mode = 1;
            1: if (m_a) mode = 2;
               else if (!m_r) begin mode = 3; cnt = TURN; end
            2: if (!m_a) begin mode = 3; cnt = TURN; end
            default: begin cnt--; if (cnt == 0) mode = 0; end
         endcase
      end
   end

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_ok && !done) begin
         check("MODEL grant", bus_grant_o, mode == 1);
         check("MODEL drive", drive_en_o, mode == 0);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int hold;
      hold = 0;
      tick(3);
      check("R1 drive in reset", drive_en_o, 1'b1);
      check("R1 grant in reset", bus_grant_o, 1'b0);
      rst_n = 1'b1;
      tick(1);
      check("R1 drive after reset", drive_en_o, 1'b1);
      check("R1 grant after reset", bus_grant_o, 1'b0);

      // R2/R3: request to grant latency
      bus_req_i = 1'b1;
      tick(2); check("R2 grant early", bus_grant_o, 1'b0);
      tick(1); check("R2 grant", bus_grant_o, 1'b1);
      check("R3 drive off with grant", drive_en_o, 1'b0);

      // R6/R7: acknowledge, prompt withdrawal, release
      bus_ack_i = 1'b1; bus_req_i = 1'b0;
      tick(2); check("R6 grant held", bus_grant_o, 1'b1);
      tick(1); check("R6 grant dropped", bus_grant_o, 1'b0);
      tick(3); check("R6 drive off while lent", drive_en_o, 1'b0);
      bus_ack_i = 1'b0;
      tick(SYNC + TURN); check("R7 drive in turnaround", drive_en_o, 1'b0);
      check("R7 grant in turnaround", bus_grant_o, 1'b0);
      tick(1); check("R7 drive resumed", drive_en_o, 1'b1);

      // R4: lock defers the grant
      seq_locked_i = 1'b1; bus_req_i = 1'b1;
      tick(6); check("R4 grant while locked", bus_grant_o, 1'b0);
      seq_locked_i = 1'b0;
      tick(1); check("R4 grant after unlock", bus_grant_o, 1'b1);

      // R8: request withdrawn without acknowledge
      bus_req_i = 1'b0;
      tick(2); check("R8 grant held", bus_grant_o, 1'b1);
      tick(1); check("R8 grant withdrawn", bus_grant_o, 1'b0);
      check("R8 drive in turnaround", drive_en_o, 1'b0);
      tick(TURN); check("R8 drive resumed", drive_en_o, 1'b1);

      // R5: no grant away from a boundary
      cyc_idle_i = 1'b0; bus_req_i = 1'b1;
      tick(5); check("R5 grant while busy", bus_grant_o, 1'b0);
      cyc_idle_i = 1'b1;
      tick(1); check("R5 grant at boundary", bus_grant_o, 1'b1);

      // R9: request still held when acknowledge drops
      bus_ack_i = 1'b1;
      tick(3); check("R9 grant dropped", bus_grant_o, 1'b0);
      bus_ack_i = 1'b0;
      tick(SYNC + TURN + 1); check("R9 drive one cycle", drive_en_o, 1'b1);
      check("R9 grant low while driving", bus_grant_o, 1'b0);
      tick(1); check("R9 grant reissued", bus_grant_o, 1'b1);
      check("R9 drive off", drive_en_o, 1'b0);
      bus_ack_i = 1'b1; bus_req_i = 1'b0;
      tick(4); bus_ack_i = 1'b0;
      tick(5); check("R7 drive after cleanup", drive_en_o, 1'b1);

      // Random phase, compared against the model every cycle
      for (int n = 0; n < 800; n++) begin
         @(negedge clk);
         seq_locked_i = ($urandom % 4) == 0;
         cyc_idle_i   = ($urandom % 3) != 0;
         if (!bus_ack_i) begin
            if (bus_grant_o && bus_req_i && ($urandom % 2) == 0) begin
               bus_ack_i = 1'b1; hold = 2 + ($urandom % 4);
            end else if (bus_grant_o && ($urandom % 6) == 0) begin
               bus_req_i = 1'b0;
            end else if (!bus_req_i && ($urandom % 5) == 0) begin
               bus_req_i = 1'b1;
            end
         end else begin
            if (($urandom % 2) == 0) bus_req_i = 1'b0;
            if (hold == 0) bus_ack_i = 1'b0; else hold--;
         end
      end
      tick(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule